// File: doc/BRIEF.md
# Bit-Serial Shift Register Adder

This block adds two unsigned W-bit numbers with one full-adder cell, one bit position per clock. A parallel-load strobe copies the two operand buses into two right-shifting registers. A start pulse then runs W bit-cycles. In each bit-cycle the cell adds the two least significant bits and a stored carry. The sum bit enters the most significant end of the first operand register, so that register holds the sum when the run ends. The final carry stays in a flip-flop as the carry-out.

A host loads the operands, pulses start and waits for the one-cycle done flag. It then reads the result bus and the carry-out, which hold until the next load or start. By default the second operand register rotates its bits back into itself while it shifts. A further start without a new load therefore adds the same second operand again, which makes the block a small serial accumulator.

Top module: `bitser_adder`

## Requirements
- R1: One clock edge with reset high drives busy, done, carry-out and the result bus to 0. Reset high during an addition ends that addition.
- R2: A load strobe while idle makes the result bus show the first operand bus value from the next cycle on.
- R3: A start pulse while idle sets busy from the next cycle on. Busy then stays high for exactly W consecutive cycles.
- R4: Done is high for exactly one cycle. That cycle is the first one in which busy is low again.
- R5: In the done cycle the result bus equals (A + B) mod 2^W and carry-out equals bit W of A + B, for any unsigned operands.
- R6: Load strobes and start pulses that arrive while busy is high change neither the result nor the length of the addition.
- R7: While idle, the result bus keeps its value until a load, and carry-out keeps its value until a start.
- R8: The carry flip-flop clears when an addition starts. Carry-out reads 0 in the first busy cycle, and no carry from an earlier addition reaches the next result.
- R9: With the recirculate option on (the default), the second operand register is unchanged after an addition. A start without a load then yields the previous result plus the same second operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Parallel-load strobe for both operands |
| op_a | input | W | First operand, which is also the seed of the result register |
| op_b | input | W | Second operand |
| start | input | 1 | Starts a W-cycle serial addition |
| busy | output | 1 | High while bit-cycles are running |
| done | output | 1 | One-cycle pulse after the last bit-cycle |
| sum | output | W | Result register contents |
| cout | output | 1 | Carry flip-flop contents, final carry after done |

## Verification
The hardest cases to reach from the ports are the ones that depend on hidden state. One is a load or start that arrives in the middle of a run. The other is a stale carry, or a rotated second operand, carried into the next run. The bench drives strobes several cycles into an addition and confirms the original sum and the full W-cycle busy window. It follows an addition that ends with a carry by a fresh small addition, so a carry leak would show up in the result. It also issues a start with no reload, which exposes the state of the hidden second register through the accumulated sum.

// File: rtl/bsa_pkg.sv
`timescale 1ns/1ps
package bsa_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bsa_state_t;
endpackage

// File: rtl/bsa_full_adder.sv
`timescale 1ns/1ps
module bsa_full_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
  end
endmodule

// File: rtl/bsa_shreg.sv
`timescale 1ns/1ps
module bsa_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         sh,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= ld_val;
    else if (sh)  q <= {ser_in, q[W-1:1]};
  end
endmodule

// File: rtl/bsa_ctrl.sv
`timescale 1ns/1ps
module bsa_ctrl
  import bsa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic start,
  output logic ld_ok,
  output logic go,
  output logic shift_en,
  output logic busy,
  output logic done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  bsa_state_t st;
  logic [CW-1:0] cnt;

  always_comb begin
    busy     = (st == ST_RUN);
    ld_ok    = load  && !busy;
    go       = start && !busy;
    shift_en = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st  <= ST_RUN;
          cnt <= '0;
        end
        ST_RUN: begin
          if (cnt == LAST) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
          cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitser_adder.sv
`timescale 1ns/1ps
module bitser_adder #(
  parameter int W        = 8,
  parameter bit B_RECIRC = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic ld_ok, go, shift_en;
  logic [W-1:0] a_q, b_q;
  logic s_bit, c_next, carry_q, b_fill;

  bsa_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .load(load), .start(start),
    .ld_ok(ld_ok), .go(go), .shift_en(shift_en),
    .busy(busy), .done(done)
  );

  bsa_full_adder u_fa (
    .x(a_q[0]), .y(b_q[0]), .ci(carry_q), .s(s_bit), .co(c_next)
  );

  bsa_shreg #(.W(W)) u_reg_a (
    .clk(clk), .rst(rst), .ld(ld_ok), .ld_val(op_a),
    .sh(shift_en), .ser_in(s_bit), .q(a_q)
  );

  generate
    if (B_RECIRC) begin : g_rot
      assign b_fill = b_q[0];
    end else begin : g_zero
      assign b_fill = 1'b0;
    end
  endgenerate

  bsa_shreg #(.W(W)) u_reg_b (
    .clk(clk), .rst(rst), .ld(ld_ok), .ld_val(op_b),
    .sh(shift_en), .ser_in(b_fill), .q(b_q)
  );

  always_ff @(posedge clk) begin
    if (rst)           carry_q <= 1'b0;
    else if (go)       carry_q <= 1'b0;
    else if (shift_en) carry_q <= c_next;
  end

  assign sum  = a_q;
  assign cout = carry_q;
endmodule

// File: rtl/bsa_checker.sv
`timescale 1ns/1ps
module bsa_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic [W-1:0] op_a,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] sum,
  input logic         cout
);
  int run_len;
  always_ff @(posedge clk) begin
    if (rst)       run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && !cout && sum == '0));

  assert_load_copy_R2: assert property (@(posedge clk) disable iff (rst)
    (load && !busy) |=> (sum == $past(op_a)));

  assert_busy_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < W));

  assert_done_after_run_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy) && $past(run_len) == W - 1));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_sum_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> $stable(sum));

  assert_cout_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(cout));

  assert_carry_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> !cout);
endmodule

bind bitser_adder bsa_checker #(.W(W)) u_bsa_chk (
  .clk(clk), .rst(rst), .load(load), .op_a(op_a), .start(start),
  .busy(busy), .done(done), .sum(sum), .cout(cout)
);

// File: tb/bitser_adder_test.sv
`timescale 1ns/1ps
module bitser_adder_test;
  localparam int W = 8;
  localparam int NV = 8;
  localparam logic [W-1:0] VA [NV] = '{8'h00, 8'hFF, 8'hFF, 8'h55, 8'h80, 8'h12, 8'h7F, 8'hC3};
  localparam logic [W-1:0] VB [NV] = '{8'h00, 8'h01, 8'hFF, 8'hAA, 8'h80, 8'h34, 8'h01, 8'h3C};
  localparam logic [W:0]   VS [NV] = '{9'h000, 9'h100, 9'h1FE, 9'h0FF, 9'h100, 9'h046, 9'h080, 9'h0FF};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic busy, done, cout;
  logic [W-1:0] sum;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bitser_adder #(.W(W)) uut (
    .clk(clk), .rst(rst), .load(load), .op_a(op_a), .op_b(op_b),
    .start(start), .busy(busy), .done(done), .sum(sum), .cout(cout)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Runs one addition; leaves time at the negedge of the done cycle.
  task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input bit do_load,
                         output logic [W-1:0] s, output logic c, output int n);
    @(negedge clk);
    if (do_load) begin
      load = 1'b1; op_a = a; op_b = b;
      @(negedge clk);
      load = 1'b0;
      chk(sum == a, "R2 load copy", 32'(sum), 32'(a));
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3 busy rise", 32'(busy), 32'd1);
    chk(cout == 1'b0, "R8 carry clear", 32'(cout), 32'd0);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    s = sum;
    c = cout;
    chk(done == 1'b1, "R4 done at end", 32'(done), 32'd1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] s;
    logic c;
    int n;
    logic [W:0] e;

    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", {30'd0, busy, done}, 32'd0);
    chk(sum == '0 && cout == 1'b0, "R1 reset data", {23'd0, cout, sum}, 32'd0);
    rst = 1'b0;

    // Vector table walk (R5, R3, R4, R7)
    for (int i = 0; i < NV; i++) begin
      run_add(VA[i], VB[i], 1'b1, s, c, n);
      chk(n == W, "R3 run length", 32'(n), 32'(W));
      chk({c, s} == VS[i], "R5 sum/carry", 32'({c, s}), 32'(VS[i]));
      @(negedge clk);
      chk(done == 1'b0, "R4 done one cycle", 32'(done), 32'd0);
      repeat (3) @(negedge clk);
      chk({cout, sum} == VS[i], "R7 hold idle", 32'({cout, sum}), 32'(VS[i]));
    end

    // R9: start without load adds the same B again (last: FF + 3C)
    run_add('0, '0, 1'b0, s, c, n);
    chk({c, s} == 9'h13B, "R9 recirculated B", 32'({c, s}), 32'h13B);

    // R8: carry from a previous run must not leak (FF+01 then 01+01)
    run_add(8'hFF, 8'h01, 1'b1, s, c, n);
    chk({c, s} == 9'h100, "R8 carry setup", 32'({c, s}), 32'h100);
    run_add(8'h01, 8'h01, 1'b1, s, c, n);
    chk({c, s} == 9'h002, "R8 no carry leak", 32'({c, s}), 32'h002);

    // R6: load and start strobes during a run are ignored
    @(negedge clk);
    load = 1'b1; op_a = 8'h0F; op_b = 8'h01;
    @(negedge clk);
    load = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    repeat (3) begin n++; @(negedge clk); end
    load = 1'b1; start = 1'b1; op_a = 8'hAA; op_b = 8'h55;
    n++; @(negedge clk);
    n++; @(negedge clk);
    load = 1'b0; start = 1'b0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk(n == W + 1, "R6 run length kept", 32'(n - 1), 32'(W));
    chk({cout, sum} == 9'h010, "R6 result kept", 32'({cout, sum}), 32'h010);
    chk(done == 1'b1, "R6 done", 32'(done), 32'd1);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && sum == 8'h10, "R6 no late start", {23'd0, busy, sum}, 32'h010);

    // R1: reset aborts a running addition
    e = 9'h0;
    run_add(8'hFF, 8'hFF, 1'b1, s, c, n);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 abort flags", {30'd0, busy, done}, 32'd0);
    chk({cout, sum} == e, "R1 abort data", 32'({cout, sum}), 32'(e));
    rst = 1'b0;
    repeat (W + 2) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 stays idle", {30'd0, busy, done}, 32'd0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule